// File: doc/BRIEF.md
# Multi-Cycle Unit Issue Checker

This block sits at the point where a decoded instruction leaves the decode stage for execution. The pipeline behind it has several functional units that take different numbers of cycles: an integer unit, a memory path, a pipelined floating-point adder, a pipelined multiplier, and a divider that accepts only one operation at a time. Each cycle the block gets one candidate instruction: its unit code, up to two source registers with use flags, and a destination register with a write flag. In the same cycle it decides whether the instruction may issue. If it may not, it raises a stall, and the whole front end holds the instruction and everything behind it.

The decision checks three things. A source must not still be waiting on an older producer (read-after-write). The destination must not have an older pending write that lands at or after the new one (write-after-write). The required unit must be free, and the single register write port must be free in the cycle the new result would be written (structural). The block tracks in-flight work in three ways: per-register countdowns, a per-unit busy timer for units that cannot accept work every cycle, and a shift register that books the write port cycle by cycle. The booking vector is an output, so the write-back stage can see which future cycles already hold a write.

Top module: `issue_checker`

## Requirements
- R1: With `in_valid` high, exactly one of `out_issue` and `out_stall` is high in that same cycle. With `in_valid` low, both are low.
- R2: Unit codes are: 0 integer, 1 memory, 2 FP add, 3 multiply, 4 divide. Result latencies are 0, 1, 3, 6 and 24 cycles. Write-back takes place 2, 2, 4, 7 and 25 cycles after the issue cycle.
- R3: An instruction that reads a register whose producer issued in cycle t with latency L cannot issue before cycle t+L+1. It issues in that cycle if nothing else blocks it. A source with its use flag low is never checked.
- R4: A divide issued in cycle t blocks any further divide until cycle t+25. Instructions for other units are not held by a busy divider.
- R5: A register-writing instruction stalls while its destination has a pending write that would land in the same cycle as its own write-back or later. A pending write that lands earlier does not block it.
- R6: At most one register write is booked per cycle. A register-writing instruction stalls if its write-back cycle is already booked. An instruction with `in_write` low never books the port and is never blocked by the port or by R5.
- R7: Bit j of `out_resv` being high in cycle c means a register write is booked for cycle c+j. An instruction that issues in cycle t with write offset D shows up as bit D-1 in cycle t+1, and that bit moves down by one each cycle.
- R8: After reset, no register is pending, no unit is busy and `out_resv` is zero.
- R9: Unit codes 5, 6 and 7 are handled exactly as the integer unit.
- R10: Inputs in cycles where `in_valid` is low, or where the instruction stalls, leave no trace. They do not book the port, do not mark a register pending and do not start a unit timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 3 | Functional unit code (R2, R9) |
| in_src_a | input | 5 | First source register |
| in_use_a | input | 1 | First source is read |
| in_src_b | input | 5 | Second source register |
| in_use_b | input | 1 | Second source is read |
| in_dst | input | 5 | Destination register |
| in_write | input | 1 | Instruction writes its destination |
| out_issue | output | 1 | Instruction issues this cycle |
| out_stall | output | 1 | Instruction and all behind it hold |
| out_resv | output | 26 | Write-port booking, bit j = cycle now+j |

## Verification
The assertions check, on every cycle, that the issue and stall outputs are mutually exclusive, that booked write slots only move down and never vanish early, and that an issued write books its slot. They also check that an issued write never lands on a slot that is already taken, and that divides are spaced by at least the divider's repeat interval. Some behaviours only the bench can show: the exact stall counts of the read-after-write and write-after-write checks for each unit, the treatment of unused sources and non-writing instructions, and the fallback of spare unit codes to the integer unit. The bench establishes these with a reference model that works in absolute cycle numbers, plus directed scenarios that count stall cycles.

// File: rtl/issue_pkg.sv
// Shared timing constants and unit decode for the issue checker.
// Assumes one register write port and one candidate instruction per cycle.
package issue_pkg;

    localparam int unsigned NUM_UNITS = 5;

    typedef enum logic [2:0] {
        U_INT  = 3'd0,
        U_MEM  = 3'd1,
        U_FADD = 3'd2,
        U_MUL  = 3'd3,
        U_DIV  = 3'd4
    } unit_e;

    // Result latency: intervening cycles before a consumer may issue.
    localparam int unsigned LAT_INT  = 0;
    localparam int unsigned LAT_MEM  = 1;
    localparam int unsigned LAT_FADD = 3;
    localparam int unsigned LAT_MUL  = 6;
    localparam int unsigned LAT_DIV  = 24;

    // Repeat interval of the divider; every other unit accepts every cycle.
    localparam int unsigned II_DIV   = 25;

    // Write-back offset from the issue cycle.
    localparam int unsigned WB_INT   = 2;
    localparam int unsigned WB_MEM   = 2;
    localparam int unsigned WB_FADD  = LAT_FADD + 1;
    localparam int unsigned WB_MUL   = LAT_MUL + 1;
    localparam int unsigned WB_DIV   = LAT_DIV + 1;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam int unsigned MAX_WB = max2(max2(max2(WB_INT, WB_MEM), max2(WB_FADD, WB_MUL)), WB_DIV);
    localparam int unsigned CW     = $clog2(max2(MAX_WB, II_DIV) + 1);
    localparam int unsigned SLOTS  = MAX_WB + 1;

    // Map a raw unit code onto a real unit; spare codes become integer.
    function automatic logic [2:0] unit_of(input logic [2:0] code);
        return (code > 3'(U_DIV)) ? 3'(U_INT) : code;
    endfunction

    function automatic logic [CW-1:0] lat_of(input logic [2:0] code);
        case (unit_of(code))
            3'(U_MEM):  return CW'(LAT_MEM);
            3'(U_FADD): return CW'(LAT_FADD);
            3'(U_MUL):  return CW'(LAT_MUL);
            3'(U_DIV):  return CW'(LAT_DIV);
            default:    return CW'(LAT_INT);
        endcase
    endfunction

    function automatic logic [CW-1:0] wb_of(input logic [2:0] code);
        case (unit_of(code))
            3'(U_MEM):  return CW'(WB_MEM);
            3'(U_FADD): return CW'(WB_FADD);
            3'(U_MUL):  return CW'(WB_MUL);
            3'(U_DIV):  return CW'(WB_DIV);
            default:    return CW'(WB_INT);
        endcase
    endfunction

    function automatic logic [CW-1:0] ii_of(input logic [2:0] code);
        return (unit_of(code) == 3'(U_DIV)) ? CW'(II_DIV) : CW'(1);
    endfunction

endpackage

// File: rtl/reg_track.sv
// Per-register scoreboard: a countdown to operand readiness and a countdown
// to the pending write-back. A load on issue overrides older state; the
// write-after-write check guarantees the older write lands first.
module reg_track #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned CW    = 5,
    localparam int unsigned RW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic [CW-1:0] set_rdy,
    input  logic [CW-1:0] set_wb,
    input  logic [RW-1:0] q_a,
    input  logic [RW-1:0] q_b,
    input  logic [RW-1:0] q_d,
    output logic          busy_a,
    output logic          busy_b,
    output logic [CW-1:0] wleft_d
);

    logic [CW-1:0] rdy_v [NREGS];
    logic [CW-1:0] wb_v  [NREGS];

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic [CW-1:0] rdy_q;
        logic [CW-1:0] wb_q;

        // Load both countdowns on a claiming issue, otherwise run them to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdy_q <= '0;
                wb_q  <= '0;
            end else if (set_en && set_reg == RW'(r)) begin
                rdy_q <= set_rdy;
                wb_q  <= set_wb;
            end else begin
                if (rdy_q != '0) rdy_q <= rdy_q - 1'b1;
                if (wb_q  != '0) wb_q  <= wb_q  - 1'b1;
            end
        end

        assign rdy_v[r] = rdy_q;
        assign wb_v[r]  = wb_q;
    end

    // Look up the three queried registers.
    always_comb begin
        busy_a  = (rdy_v[q_a] != '0);
        busy_b  = (rdy_v[q_b] != '0);
        wleft_d = wb_v[q_d];
    end

endmodule

// File: rtl/unit_timers.sv
// Busy timers for functional units whose repeat interval exceeds one cycle.
// Units that accept work every cycle get no timer (generate picks the variant).
module unit_timers #(
    parameter int unsigned NUM_UNITS = 5,
    parameter int unsigned CW        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_en,
    input  logic [2:0]           start_unit,
    output logic [NUM_UNITS-1:0] busy
);

    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
        localparam int unsigned IIK = int'(issue_pkg::ii_of(3'(k)));
        if (IIK > 1) begin : g_timer
            logic [CW-1:0] cnt_q;

            // Load repeat interval minus one on a start, count down to free.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (start_en && start_unit == 3'(k))
                    cnt_q <= CW'(IIK - 1);
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end

            assign busy[k] = (cnt_q != '0);
        end else begin : g_free
            assign busy[k] = 1'b0;
        end
    end

endmodule

// File: rtl/wport_ring.sv
// Write-port booking shift register. Bit j set means a write-back is booked
// for the cycle j cycles from now. Assumes claimed offsets are at least 1.
module wport_ring #(
    parameter int unsigned SLOTS = 26,
    parameter int unsigned CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    chk_slot,
    input  logic             claim,
    output logic             taken,
    output logic [SLOTS-1:0] resv
);

    logic [SLOTS-1:0] resv_q;

    // Age every booking by one cycle and add the new claim one slot lower.
    always_ff @(posedge clk) begin
        if (!rst_n)
            resv_q <= '0;
        else
            resv_q <= (resv_q >> 1) | (claim ? (SLOTS'(1) << (chk_slot - 1'b1)) : '0);
    end

    // Report whether the requested slot already holds a write.
    always_comb begin
        taken = (32'(chk_slot) < SLOTS) ? resv_q[chk_slot] : 1'b0;
        resv  = resv_q;
    end

endmodule

// File: rtl/issue_checker.sv
// Issue decision for a pipeline with units of unequal latency. Combines the
// read-after-write, write-after-write, unit-busy and write-port checks into
// one same-cycle issue/stall answer. Assumes at most one candidate per cycle
// and that a stalled candidate is re-presented by the front end.
module issue_checker #(
    parameter int unsigned NREGS = 32,
    localparam int unsigned RW    = $clog2(NREGS),
    localparam int unsigned SLOTS = issue_pkg::SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_unit,
    input  logic [RW-1:0]    in_src_a,
    input  logic             in_use_a,
    input  logic [RW-1:0]    in_src_b,
    input  logic             in_use_b,
    input  logic [RW-1:0]    in_dst,
    input  logic             in_write,
    output logic             out_issue,
    output logic             out_stall,
    output logic [SLOTS-1:0] out_resv
);
    import issue_pkg::*;

    logic [CW-1:0]        lat;
    logic [CW-1:0]        wbd;
    logic                 busy_a;
    logic                 busy_b;
    logic [CW-1:0]        wleft_d;
    logic                 slot_taken;
    logic [NUM_UNITS-1:0] unit_busy;
    logic                 raw_hit;
    logic                 waw_hit;
    logic                 port_hit;
    logic                 unit_hit;
    logic                 hazard;

    reg_track #(.NREGS(NREGS), .CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (out_issue & in_write),
        .set_reg (in_dst),
        .set_rdy (lat),
        .set_wb  (wbd),
        .q_a     (in_src_a),
        .q_b     (in_src_b),
        .q_d     (in_dst),
        .busy_a  (busy_a),
        .busy_b  (busy_b),
        .wleft_d (wleft_d)
    );

    unit_timers #(.NUM_UNITS(NUM_UNITS), .CW(CW)) u_units (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_en   (out_issue),
        .start_unit (unit_of(in_unit)),
        .busy       (unit_busy)
    );

    wport_ring #(.SLOTS(SLOTS), .CW(CW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_slot (wbd),
        .claim    (out_issue & in_write),
        .taken    (slot_taken),
        .resv     (out_resv)
    );

    // Decode timing, evaluate each hazard class and form the issue answer.
    always_comb begin
        lat       = lat_of(in_unit);
        wbd       = wb_of(in_unit);
        raw_hit   = (in_use_a & busy_a) | (in_use_b & busy_b);
        waw_hit   = in_write & (wleft_d > wbd);
        port_hit  = in_write & slot_taken;
        unit_hit  = unit_busy[unit_of(in_unit)];
        hazard    = raw_hit | waw_hit | port_hit | unit_hit;
        out_issue = in_valid & ~hazard;
        out_stall = in_valid &  hazard;
    end

endmodule

// File: rtl/issue_checker_sva.sv
// Property checker for issue_checker, attached by bind below.
module issue_checker_sva #(
    parameter int unsigned SLOTS = issue_pkg::SLOTS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_unit,
    input logic             in_write,
    input logic             out_issue,
    input logic             out_stall,
    input logic [SLOTS-1:0] out_resv
);
    import issue_pkg::*;

    logic [CW-1:0] slot_c;
    logic [CW-1:0] slot_m1;
    logic [CW:0]   div_gap;
    logic          is_div;

    // Decode the slot this candidate would book.
    always_comb begin
        slot_c  = wb_of(in_unit);
        slot_m1 = slot_c - 1'b1;
        is_div  = (unit_of(in_unit) == 3'(U_DIV));
    end

    // Count cycles since the last divide issue, saturating at the interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_gap <= (CW+1)'(II_DIV);
        else if (out_issue && is_div)
            div_gap <= (CW+1)'(1);
        else if (div_gap < (CW+1)'(II_DIV))
            div_gap <= div_gap + 1'b1;
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (out_issue ^ out_stall)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!out_issue && !out_stall)); // R1
    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_issue && is_div) |-> (div_gap >= (CW+1)'(II_DIV))); // R4
    AST_PORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_issue && in_write) |-> !out_resv[slot_c]); // R6
    AST_CLAIM_BOOKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_issue && in_write) |=> out_resv[$past(slot_m1)]); // R7
    AST_RESV_AGES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(out_resv) >> 1) & ~out_resv) == '0)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_resv == '0)); // R8

endmodule

bind issue_checker issue_checker_sva #(.SLOTS(SLOTS)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_unit   (in_unit),
    .in_write  (in_write),
    .out_issue (out_issue),
    .out_stall (out_stall),
    .out_resv  (out_resv)
);

// File: tb/test_issue_checker.sv
// Bench: absolute-cycle reference model compared every cycle, plus directed
// scenarios that count stall cycles.
module test_issue_checker;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_unit = '0;
    logic [4:0]    in_src_a = '0;
    logic          in_use_a = 1'b0;
    logic [4:0]    in_src_b = '0;
    logic          in_use_b = 1'b0;
    logic [4:0]    in_dst = '0;
    logic          in_write = 1'b0;
    logic          out_issue;
    logic          out_stall;
    logic [NS-1:0] out_resv;

    int total = 0;
    int bad = 0;
    int now = 0;
    int cyc = 0;
    int ready_at [32];
    int write_at [32];
    int div_free = 0;
    bit booked [int];

    issue_checker i_issue_checker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
        .in_src_a(in_src_a), .in_use_a(in_use_a), .in_src_b(in_src_b),
        .in_use_b(in_use_b), .in_dst(in_dst), .in_write(in_write),
        .out_issue(out_issue), .out_stall(out_stall), .out_resv(out_resv)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int b_lat(input logic [2:0] u);
        case (u)
            3'd1: return 1;
            3'd2: return 3;
            3'd3: return 6;
            3'd4: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic int b_wb(input logic [2:0] u);
        case (u)
            3'd2: return 4;
            3'd3: return 7;
            3'd4: return 25;
            default: return 2;
        endcase
    endfunction

    function automatic bit model_go();
        int d;
        if (!in_valid) return 1'b0;
        d = b_wb(in_unit);
        if (in_use_a && ready_at[in_src_a] > now) return 1'b0;
        if (in_use_b && ready_at[in_src_b] > now) return 1'b0;
        if (in_write && write_at[in_dst] >= now + d) return 1'b0;
        if (in_write && booked.exists(now + d)) return 1'b0;
        if (in_unit == 3'd4 && div_free > now) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, got, exp, now);
        end
    endtask

    // One clock: drive, compare against the model mid-cycle, then advance.
    task automatic step(input bit v, input logic [2:0] u, input logic [4:0] a, input bit ua,
                        input logic [4:0] b, input bit ub, input logic [4:0] d, input bit wr,
                        input string tag, output bit went);
        logic [NS-1:0] er;
        bit eg;
        @(negedge clk);
        in_valid = v; in_unit = u; in_src_a = a; in_use_a = ua;
        in_src_b = b; in_use_b = ub; in_dst = d; in_write = wr;
        #(CLK_PERIOD/4);
        eg = model_go();
        for (int j = 0; j < NS; j++) er[j] = booked.exists(now + j);
        check({tag, " issue"}, 32'(out_issue), 32'(eg));
        check({tag, " stall"}, 32'(out_stall), 32'(v & ~eg));
        check({tag, " resv"}, 32'(out_resv), 32'(er));
        went = eg;
        if (eg) begin
            if (wr) begin
                ready_at[d] = now + b_lat(u) + 1;
                write_at[d] = now + b_wb(u);
                booked[now + b_wb(u)] = 1'b1;
            end
            if (u == 3'd4) div_free = now + 25;
        end
        @(posedge clk);
        now++;
    endtask

    task automatic idle(input int n);
        bit g;
        for (int i = 0; i < n; i++) step(1'b0, 3'd4, 5'd1, 1'b1, 5'd2, 1'b1, 5'd3, 1'b1, "R10 idle", g);
    endtask

    // Present one instruction until it issues; report the stall count.
    task automatic send(input logic [2:0] u, input logic [4:0] a, input bit ua,
                        input logic [4:0] b, input bit ub, input logic [4:0] d, input bit wr,
                        input string tag, output int waits);
        bit g;
        waits = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b1, u, a, ua, b, ub, d, wr, tag, g);
            if (g) break;
            waits++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w;
        bit g;
        logic [31:0] lf;
        for (int r = 0; r < 32; r++) begin ready_at[r] = 0; write_at[r] = -1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 resv in reset", 32'(out_resv), 32'd0);
        rst_n = 1'b1;

        // R8: first instruction after reset issues at once
        send(3'd0, 5'd1, 1'b1, 5'd2, 1'b1, 5'd3, 1'b1, "R8 first", w);
        check("R8 first waits", w, 0);
        idle(30);

        // R3/R2: stall count per producer unit equals its latency
        for (int u = 0; u < 5; u++) begin
            send(3'(u), 5'd0, 1'b0, 5'd0, 1'b0, 5'd4, 1'b1, "R2 producer", w);
            send(3'd0, 5'd9, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, "R3 consumer", w);
            check("R3 raw stalls", w, b_lat(3'(u)));
            idle(30);
        end

        // R3: an unused source is not checked
        send(3'd3, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, "R3 producer", w);
        send(3'd0, 5'd5, 1'b0, 5'd5, 1'b0, 5'd0, 1'b0, "R3 unused src", w);
        check("R3 unused src waits", w, 0);
        idle(30);

        // R4: divider repeat interval, other units unaffected
        send(3'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd10, 1'b1, "R4 div1", w);
        send(3'd2, 5'd0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1, "R4 fadd", w);
        check("R4 fadd while div busy", w, 0);
        send(3'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd11, 1'b1, "R4 div2", w);
        check("R4 div2 stalls", w, 23);
        idle(30);

        // R5: older later write blocks, older earlier write does not
        send(3'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, "R5 div", w);
        send(3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, "R5 int", w);
        check("R5 waw stalls", w, 23);
        idle(30);
        send(3'd3, 5'd0, 1'b0, 5'd0, 1'b0, 5'd6, 1'b1, "R5 mul", w);
        send(3'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd6, 1'b1, "R5 div later", w);
        check("R5 no waw stall", w, 0);
        idle(30);

        // R6: port conflict, non-writing instruction passes through
        send(3'd3, 5'd0, 1'b0, 5'd0, 1'b0, 5'd7, 1'b1, "R6 mul", w);
        idle(2);
        send(3'd2, 5'd0, 1'b0, 5'd0, 1'b0, 5'd8, 1'b1, "R6 fadd", w);
        check("R6 port stall", w, 1);
        send(3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd20, 1'b0, "R6 nowrite", w);
        check("R6 nowrite waits", w, 0);
        send(3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd9, 1'b1, "R6 int", w);
        check("R6 second port stall", w, 1);
        idle(30);

        // R9: spare codes behave as integer
        send(3'd6, 5'd0, 1'b0, 5'd0, 1'b0, 5'd13, 1'b1, "R9 code6", w);
        send(3'd0, 5'd13, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, "R9 consumer", w);
        check("R9 consumer waits", w, 0);
        send(3'd7, 5'd0, 1'b0, 5'd0, 1'b0, 5'd14, 1'b1, "R9 code7a", w);
        send(3'd7, 5'd0, 1'b0, 5'd0, 1'b0, 5'd15, 1'b1, "R9 code7b", w);
        check("R9 back to back", w, 0);
        idle(30);

        // R10: invalid cycles left nothing behind
        check("R10 resv empty", 32'(out_resv), 32'd0);
        send(3'd4, 5'd1, 1'b1, 5'd2, 1'b1, 5'd3, 1'b1, "R10 div", w);
        check("R10 div free", w, 0);
        idle(30);

        // R1/R5/R6/R7: pseudo-random mix against the model
        lf = 32'h1d2c3b4a;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[0] | lf[1], lf[4:2], {2'b0, lf[7:5]}, lf[8], {2'b0, lf[11:9]}, lf[12],
                 {2'b0, lf[15:13]}, lf[16] | lf[17], "R1 mix", g);
        end
        idle(30);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule